// File: doc/BRIEF.md
# Multi-Mode Four-Channel Pulse Counter

This block keeps four independent 16-bit up/down position counters. Each channel watches two input lines and turns them into count steps in one of three formats chosen at run time: A/B quadrature decoded at four counts per line cycle, a forward line and a reverse line that each count on their rising edge, or a pulse line that counts on its rising edge with a sign line that sets the direction. A fourth mode code stops counting.

A controller drives one 16-bit command word holding a four-bit field per channel. This field carries the count enable, a clear request and the input format. It reads back a 16-bit status word packed the same way, with an active echo, a clear acknowledge and the direction of the latest step. The four count values appear side by side on a flat output bus, channel 0 in the low 16 bits. All line inputs pass through a synchronizer before decoding, so the lines may be fully asynchronous to the clock.

Top module: `multi_pulse_counter`

## Requirements
- R1: Channel k takes its command from cmd_word bits 4k+3..4k: bit 0 is count enable, bit 1 is clear, bits 3:2 select the format (00 quadrature, 01 forward/reverse lines, 10 pulse plus sign, 11 no counting).
- R2: Channel k reports on status_word bits 4k+3..4k: bit 0 is the enable bit registered one cycle late, bit 1 is the clear acknowledge, bit 2 is direction, bit 3 is always 0.
- R3: In format 00, with state {A,B} stepping 00,10,11,01,00 (A leading) each transition adds 1; the reverse order subtracts 1.
- R4: In format 00, a change of both lines in one sampled step leaves both count and direction unchanged.
- R5: In format 01, a rising edge on line A adds 1 and a rising edge on line B subtracts 1; both rising in the same sampled step leaves the count unchanged.
- R6: In format 10, a rising edge on line A adds 1 when line B is 0 and subtracts 1 when line B is 1; line B edges alone do nothing.
- R7: In format 11, no line activity changes the count.
- R8: With the enable bit 0, line activity is ignored and the count holds.
- R9: The count is unsigned 16-bit: adding 1 to 0xFFFF gives 0 and subtracting 1 from 0 gives 0xFFFF.
- R10: While clear is 1 the count is 0 from the next clock on, even with enable set; the clear acknowledge is 1 one cycle after clear rises and 0 one cycle after clear falls.
- R11: The direction bit becomes 0 after a counted up step and 1 after a counted down step, and holds otherwise.
- R12: A line change driven between clock edges shows in the count after the third rising edge and not after the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_word | input | 16 | Packed per-channel command fields |
| line_a | input | 4 | First input line of each channel |
| line_b | input | 4 | Second input line of each channel |
| status_word | output | 16 | Packed per-channel status fields |
| count_flat | output | 64 | Four 16-bit counts, channel 0 lowest |

## Verification
The bench builds the block with its defaults: four channels, 16-bit counts and a two-stage synchronizer. The 16-bit width keeps the wrap points at 0 and 0xFFFF a single step away from a cleared count, so both wraps are reached by directed pulses. Four channels let random stimulus mix all formats, enable states and clears in the same run, and the two-stage synchronizer fixes the three-edge latency measured in the latency check.

// File: rtl/pcnt_pkg.sv
package pcnt_pkg;
  typedef enum logic [1:0] {
    FMT_QUAD = 2'b00,
    FMT_UPDN = 2'b01,
    FMT_PSGN = 2'b10,
    FMT_OFF  = 2'b11
  } pcnt_fmt_e;

  // Command field of one channel (MSB first)
  typedef struct packed {
    logic [1:0] fmt;
    logic       clr;
    logic       en;
  } pcnt_cmd_t;

  // Status field of one channel (MSB first)
  typedef struct packed {
    logic spare;
    logic dir;
    logic done;
    logic active;
  } pcnt_stat_t;

  localparam int FIELD_W = 4;
endpackage

// File: rtl/pcnt_sync.sv
module pcnt_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= '0;
    end else begin
      chain[0] <= d;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/pcnt_decode.sv
module pcnt_decode
  import pcnt_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       a,
  input  logic       b,
  input  logic [1:0] fmt,
  output logic       step_up,
  output logic       step_dn
);
  logic       a_q, b_q;
  logic [1:0] pos_old, pos_new, pos_diff;

  always_ff @(posedge clk) begin
    if (rst) begin
      a_q <= 1'b0;
      b_q <= 1'b0;
    end else begin
      a_q <= a;
      b_q <= b;
    end
  end

  // Gray-coded position: 00->0, 10->1, 11->2, 01->3
  assign pos_old  = {b_q, a_q ^ b_q};
  assign pos_new  = {b,   a ^ b};
  assign pos_diff = pos_new - pos_old;

  always_comb begin
    step_up = 1'b0;
    step_dn = 1'b0;
    unique case (pcnt_fmt_e'(fmt))
      FMT_QUAD: begin
        step_up = (pos_diff == 2'd1);
        step_dn = (pos_diff == 2'd3);
      end
      FMT_UPDN: begin
        step_up = a & ~a_q & ~(b & ~b_q);
        step_dn = b & ~b_q & ~(a & ~a_q);
      end
      FMT_PSGN: begin
        step_up = a & ~a_q & ~b;
        step_dn = a & ~a_q & b;
      end
      default: ;
    endcase
  end

  // R4: a two-line jump in quadrature yields no step
  assert_quad_jump_R4: assert property (@(posedge clk) disable iff (rst)
    (fmt == 2'b00 && a != a_q && b != b_q) |-> !(step_up || step_dn));
  assert_one_step_R5: assert property (@(posedge clk) disable iff (rst)
    $onehot0({step_up, step_dn}));
endmodule

// File: rtl/pcnt_channel.sv
module pcnt_channel
  import pcnt_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  pcnt_cmd_t     cmd,
  input  logic          step_up,
  input  logic          step_dn,
  output logic [CW-1:0] count,
  output pcnt_stat_t    stat
);
  logic live;
  assign live = cmd.en & ~cmd.clr;

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
      stat  <= '0;
    end else begin
      stat.active <= cmd.en;
      stat.done   <= cmd.clr;
      stat.spare  <= 1'b0;
      if (cmd.clr) begin
        count <= '0;
      end else if (live && step_up) begin
        count    <= count + CW'(1);
        stat.dir <= 1'b0;
      end else if (live && step_dn) begin
        count    <= count - CW'(1);
        stat.dir <= 1'b1;
      end
    end
  end

  assert_hold_disabled_R8: assert property (@(posedge clk) disable iff (rst)
    (!cmd.en && !cmd.clr) |=> $stable(count));
  assert_clear_zero_R10: assert property (@(posedge clk) disable iff (rst)
    cmd.clr |=> (count == '0 && stat.done));
  assert_clear_ack_drop_R10: assert property (@(posedge clk) disable iff (rst)
    !cmd.clr |=> !stat.done);
  assert_unit_step_R9: assert property (@(posedge clk) disable iff (rst)
    !cmd.clr |=> (count == $past(count) || count == $past(count) + CW'(1)
                  || count == $past(count) - CW'(1)));
  assert_fmt_off_R7: assert property (@(posedge clk) disable iff (rst)
    (cmd.fmt == 2'b11 && !cmd.clr) |=> $stable(count));
  assert_dir_up_R11: assert property (@(posedge clk) disable iff (rst)
    (live && step_up) |=> !stat.dir);
  assert_active_echo_R2: assert property (@(posedge clk) disable iff (rst)
    cmd.en |=> stat.active);
endmodule

// File: rtl/multi_pulse_counter.sv
module multi_pulse_counter
  import pcnt_pkg::*;
#(
  parameter int NCH         = 4,
  parameter int CW          = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [FIELD_W*NCH-1:0] cmd_word,
  input  logic [NCH-1:0]       line_a,
  input  logic [NCH-1:0]       line_b,
  output logic [FIELD_W*NCH-1:0] status_word,
  output logic [NCH*CW-1:0]    count_flat
);
  genvar k;
  generate
    for (k = 0; k < NCH; k++) begin : g_ch
      logic [1:0]  ab_sync;
      logic        up, dn;
      pcnt_cmd_t   cmd_k;
      pcnt_stat_t  stat_k;

      assign cmd_k = pcnt_cmd_t'(cmd_word[FIELD_W*k +: FIELD_W]);

      pcnt_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst),
        .d({line_a[k], line_b[k]}),
        .q(ab_sync)
      );

      pcnt_decode u_dec (
        .clk(clk), .rst(rst),
        .a(ab_sync[1]), .b(ab_sync[0]),
        .fmt(cmd_k.fmt),
        .step_up(up), .step_dn(dn)
      );

      pcnt_channel #(.CW(CW)) u_cnt (
        .clk(clk), .rst(rst),
        .cmd(cmd_k),
        .step_up(up), .step_dn(dn),
        .count(count_flat[CW*k +: CW]),
        .stat(stat_k)
      );

      assign status_word[FIELD_W*k +: FIELD_W] = stat_k;

      assert_spare_low_R2: assert property (@(posedge clk) disable iff (rst)
        !status_word[FIELD_W*k+3]);
    end
  endgenerate
endmodule

// File: tb/tb_multi_pulse_counter.sv
module tb_multi_pulse_counter;
  localparam int PERIOD = 10;
  localparam int NCH = 4;
  localparam int CW  = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [15:0] cmd_word = '0;
  logic [3:0]  line_a = '0, line_b = '0;
  logic [15:0] status_word;
  logic [63:0] count_flat;

  int checks = 0, errors = 0;
  logic [15:0] m_cnt [NCH];
  logic        m_dir [NCH];

  always #(PERIOD/2) clk = ~clk;

  multi_pulse_counter dut (
    .clk(clk), .rst(rst), .cmd_word(cmd_word),
    .line_a(line_a), .line_b(line_b),
    .status_word(status_word), .count_flat(count_flat)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int model_step(logic [1:0] f, logic oa, logic ob, logic na, logic nb);
    logic [1:0] po, pn, d;
    int r;
    r = 0;
    case (f)
      2'b00: begin
        po = {ob, oa ^ ob}; pn = {nb, na ^ nb}; d = pn - po;
        if (d == 2'd1) r = 1; else if (d == 2'd3) r = -1;
      end
      2'b01: r = ((!oa && na) ? 1 : 0) - ((!ob && nb) ? 1 : 0);
      2'b10: if (!oa && na) r = nb ? -1 : 1;
      default: r = 0;
    endcase
    return r;
  endfunction

  function automatic logic [15:0] exp_status();
    logic [15:0] s;
    for (int c = 0; c < NCH; c++)
      s[4*c +: 4] = {1'b0, m_dir[c], cmd_word[4*c+1], cmd_word[4*c]};
    return s;
  endfunction

  task automatic check_all(input string req);
    for (int c = 0; c < NCH; c++)
      check(req, {16'h0, count_flat[CW*c +: CW]}, {16'h0, m_cnt[c]});
    check(req, {16'h0, status_word}, {16'h0, exp_status()});
  endtask

  task automatic apply(input logic [15:0] nc, input logic [3:0] na, input logic [3:0] nb,
                       input string req);
    @(negedge clk);
    for (int c = 0; c < NCH; c++) begin
      int s;
      if (nc[4*c+1]) m_cnt[c] = '0;
      else if (nc[4*c]) begin
        s = model_step(nc[4*c+2 +: 2], line_a[c], line_b[c], na[c], nb[c]);
        if (s != 0) begin
          m_cnt[c] = m_cnt[c] + 16'(s);
          m_dir[c] = (s < 0);
        end
      end
    end
    cmd_word = nc; line_a = na; line_b = nb;
    repeat (4) @(negedge clk);
    check_all(req);
  endtask

  initial begin
    #(PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int c = 0; c < NCH; c++) begin m_cnt[c] = '0; m_dir[c] = 1'b0; end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check_all("R2 reset");

    // R1/R5 channel 0 format 01 enabled; R12 latency
    apply(16'h0005, 4'h0, 4'h0, "R1");
    line_a[0] = 1'b1;
    @(negedge clk); @(negedge clk);
    check("R12 not yet", {16'h0, count_flat[15:0]}, 32'h0);
    @(negedge clk);
    check("R12 third edge", {16'h0, count_flat[15:0]}, 32'h1);
    m_cnt[0] = 16'd1; m_dir[0] = 1'b0;
    apply(16'h0005, 4'h0, 4'h0, "R5");
    // R9 down through zero and back up
    apply(16'h0005, 4'h0, 4'h1, "R5 down");
    apply(16'h0005, 4'h0, 4'h0, "R5");
    apply(16'h0005, 4'h0, 4'h1, "R9 wrap down");
    check("R9 ffff", {16'h0, count_flat[15:0]}, 32'hFFFF);
    check("R11 dir rev", {31'h0, status_word[2]}, 32'h1);
    apply(16'h0005, 4'h1, 4'h0, "R9 wrap up");
    check("R9 zero", {16'h0, count_flat[15:0]}, 32'h0);
    apply(16'h0005, 4'h0, 4'h0, "R5");
    apply(16'h0005, 4'h1, 4'h1, "R5 both");
    apply(16'h0005, 4'h0, 4'h0, "R5");

    // R3 quadrature forward on channel 1 (field bits 7:4 = 0001)
    apply(16'h0010, 4'h2, 4'h0, "R3");
    apply(16'h0010, 4'h2, 4'h2, "R3");
    apply(16'h0010, 4'h0, 4'h2, "R3");
    apply(16'h0010, 4'h0, 4'h0, "R3");
    check("R3 four", {16'h0, count_flat[31:16]}, 32'h4);
    apply(16'h0010, 4'h0, 4'h2, "R3 rev");
    apply(16'h0010, 4'h2, 4'h0, "R4 jump");
    check("R4 hold", {16'h0, count_flat[31:16]}, 32'h3);

    // R6 pulse-plus-sign on channel 2 (field 1001)
    apply(16'h0900, 4'h4, 4'h0, "R6 up");
    apply(16'h0900, 4'h0, 4'h4, "R6 sign only");
    apply(16'h0900, 4'h4, 4'h4, "R6 down");
    apply(16'h0900, 4'h0, 4'h0, "R6");
    // R7 format 11 on channel 3 (1101)
    apply(16'hD000, 4'h8, 4'h8, "R7");
    apply(16'hD000, 4'h0, 4'h0, "R7");
    // R8 disabled format 01 on channel 3 (0100)
    apply(16'h4000, 4'h8, 4'h0, "R8");
    check("R8 hold", {16'h0, count_flat[63:48]}, 32'h0);
    apply(16'h4000, 4'h0, 4'h0, "R8");

    // R10 clear timing on channel 0 while enabled
    apply(16'h0005, 4'h1, 4'h0, "R10 pre");
    @(negedge clk);
    cmd_word = 16'h0007;
    @(negedge clk);
    check("R10 zero", {16'h0, count_flat[15:0]}, 32'h0);
    check("R10 ack up", {31'h0, status_word[1]}, 32'h1);
    cmd_word = 16'h0005;
    @(negedge clk);
    check("R10 ack down", {31'h0, status_word[1]}, 32'h0);
    m_cnt[0] = '0;
    apply(16'h0005, 4'h0, 4'h0, "R10 after");

    // Random mix
    void'($urandom(32'd12345));
    for (int it = 0; it < 400; it++) begin
      logic [15:0] nc;
      logic [3:0] na, nb;
      nc = cmd_word; na = line_a; nb = line_b;
      for (int c = 0; c < NCH; c++) begin
        int r;
        r = $urandom_range(0, 15);
        if (r < 6)       na[c] = ~na[c];
        else if (r < 11) nb[c] = ~nb[c];
        else if (r < 12) begin na[c] = ~na[c]; nb[c] = ~nb[c]; end
        else if (r < 15) nc[4*c +: 4] = {2'($urandom_range(0, 3)), 1'b0,
                                         1'($urandom_range(0, 3) != 0)};
        else             nc[4*c+1] = ~nc[4*c+1];
      end
      apply(nc, na, nb, "R1/R3/R5/R6 random");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule